// File: doc/BRIEF.md
# Serial flash page-write controller

This block gathers a page of user bytes and programs it into a serial NOR flash over a single-bit SPI link (mode 0, serial clock at half the system clock). The user strobes bytes into a local page store. The store holds only the newest page, so older bytes are dropped once a full page has been exceeded. The user then presents a start address and raises the write command with the enable qualifier high.

On an accepted command the block first reads the flash status register and checks the block-protect field. A protected target cancels the write with a short flag pulse. Otherwise the block issues write-enable as its own transaction, then page-program with the start address and the buffered bytes. It then polls status until the device reports that programming is over. Only the start address is sent. The device advances the address itself and wraps within the page, so a start in mid-page folds the overflow back to the page start.

Top module: `spi_page_writer`

## Requirements
- R1: While the block is idle, every clock edge with `load_i` high appends `data_i` to the page store. Strobes while a command is in progress (`busy_o` high or the cancel pulse active) are ignored.
- R2: The store keeps only the latest 256 bytes. On a longer burst the earliest bytes are lost, and the kept bytes go to the flash in the order they were loaded.
- R3: A write runs these SPI transactions, each framed by its own low period of `spi_cs_no`: status read (opcode 0x05), write-enable (0x06), page-program (0x02), then a status read (0x05) that repeats status bytes until bit 0 is 0. Page-program carries the address as ADDR_W/8 bytes, most significant first, then the data bytes. Data goes MSB first in SPI mode 0, with `spi_sclk_o` period two clocks and `spi_sclk_o` low whenever `spi_cs_no` is high.
- R4: Only the start address is sent. All buffered bytes follow it even past the page end, so the device stores bytes that would cross the page boundary at the start of the same page.
- R5: `write_i`, `wren_i` and `addr_i` are registered on the rising edge. `busy_o` goes high on the second rising edge after `write_i` is first seen high and stays high until a poll status byte shows bit 0 clear.
- R6: If `wren_i` is low when `write_i` is registered, no SPI transaction takes place and `busy_o` stays low.
- R7: The status bits [4:2] form a protect field BP. A nonzero BP protects addresses at or above 2^MEM_W − 2^MEM_W/2^(7−BP). A write to such an address sends no write-enable, drops `busy_o`, and raises `illegal_write_o` for exactly two cycles.
- R8: If `write_i` and `wren_i` are still high when `busy_o` falls, the block starts another write.
- R9: The page store is emptied when a write completes or is cancelled, but not when a command is ignored for a low `wren_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Byte strobe into the page store |
| data_i | input | 8 | Byte to store |
| addr_i | input | ADDR_W | Start address of the page write |
| write_i | input | 1 | Write command |
| wren_i | input | 1 | Write-enable qualifier |
| busy_o | output | 1 | Command in progress |
| illegal_write_o | output | 1 | Two-cycle pulse on a cancelled write |
| spi_sclk_o | output | 1 | SPI serial clock |
| spi_cs_no | output | 1 | SPI chip select, active low |
| spi_mosi_o | output | 1 | SPI data to flash |
| spi_miso_i | input | 1 | SPI data from flash |

## Verification
The hardest state to reach is the re-trigger. The qualifier and command must still be high at the exact cycle the final poll byte shows programming is over, with a buffer that was just emptied. The bench holds both inputs high through a whole write and waits for a second rise of busy before releasing them. Its flash model then confirms a second page-program with zero data bytes. Protection is reached by the bench's flash model answering with programmed protect bits. The bench writes just below and at the protected boundary, and checks that no write-enable transaction occurs.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RS_CMD, ST_RS_DAT, ST_GAP, ST_WE, ST_PP_CMD,
    ST_PP_ADR, ST_PP_DAT, ST_PL_CMD, ST_PL_DAT, ST_CANCEL
  } pw_state_e;

  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PP   = 8'h02;
endpackage

// File: rtl/pw_page_buf.sv
module pw_page_buf #(
  parameter int DEPTH = 256,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [7:0]       din_i,
  input  logic             clear_i,
  input  logic             rd_load_i,
  input  logic             rd_next_i,
  output logic [7:0]       dout_o,
  output logic [CNT_W-1:0] count_o
);
  logic [7:0]       mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;

  always_ff @(posedge clk_i) if (push_i) mem_q[wp_q] <= din_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; count_o <= '0;
    end else begin
      if (clear_i) count_o <= '0;
      else if (push_i) begin
        wp_q <= wp_q + 1'b1;
        if (count_o != CNT_W'(DEPTH)) count_o <= count_o + 1'b1;
      end
      // oldest kept byte; a full count truncates to zero so rp = wp
      if (rd_load_i)      rp_q <= wp_q - count_o[PTR_W-1:0];
      else if (rd_next_i) rp_q <= rp_q + 1'b1;
    end

  assign dout_o = mem_q[rp_q];

  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
  a_r2_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == CNT_W'(DEPTH) && push_i && !clear_i) |=> count_o == CNT_W'(DEPTH));
endmodule

// File: rtl/pw_spi_shift.sv
module pw_spi_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sclk_o,
  output logic       mosi_o
);
  logic       ph_q;
  logic [2:0] bit_q;
  logic [7:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      busy_o <= 1'b0; done_o <= 1'b0; ph_q <= 1'b0;
      bit_q <= '0; sh_q <= '0; rx_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o <= 1'b1; ph_q <= 1'b0; bit_q <= '0; sh_q <= tx_i;
      end else if (busy_o) begin
        if (!ph_q) begin
          ph_q <= 1'b1;
          rx_o <= {rx_o[6:0], miso_i};
        end else begin
          ph_q  <= 1'b0;
          sh_q  <= {sh_q[6:0], 1'b0};
          bit_q <= bit_q + 1'b1;
          if (bit_q == 3'd7) begin
            busy_o <= 1'b0; done_o <= 1'b1;
          end
        end
      end
    end

  assign sclk_o = ph_q;
  assign mosi_o = sh_q[7];

  a_r3_mosi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o));
  a_r3_half_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |=> !sclk_o);
endmodule

// File: rtl/spi_page_writer.sv
module spi_page_writer
  import pw_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256,
  parameter int MEM_W      = 24,
  localparam int ADDR_BYTES = ADDR_W / 8,
  localparam int AB_W       = $clog2(ADDR_BYTES + 1),
  localparam int CNT_W      = $clog2(PAGE_BYTES + 1),
  localparam logic [63:0] MEM_SIZE = 64'd1 << MEM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [7:0]        data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic              wren_i,
  output logic              busy_o,
  output logic              illegal_write_o,
  output logic              spi_sclk_o,
  output logic              spi_cs_no,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i
);
  pw_state_e         state_q, ret_q;
  logic              write_q, wren_q, pend_q, cancel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [AB_W-1:0]   ab_q;
  logic [CNT_W-1:0]  left_q, buf_cnt;
  logic [7:0]        tx_byte, buf_dout, rx_byte;
  logic              xfer, start, sh_busy, sh_done, accept, prot, buf_clear, rd_next;
  logic [ADDR_W-1:0] adr_sh;

  function automatic logic prot_hit(input logic [2:0] bp, input logic [ADDR_W-1:0] a);
    logic [63:0] lo;
    lo = MEM_SIZE - (MEM_SIZE >> (3'd7 - bp));
    return (bp != 3'd0) && ({{(64-ADDR_W){1'b0}}, a} >= lo);
  endfunction

  assign accept    = (state_q == ST_IDLE) && write_q && wren_q;
  assign prot      = prot_hit(rx_byte[4:2], addr_q);
  assign buf_clear = sh_done && (((state_q == ST_PL_DAT) && !rx_byte[0]) ||
                                 ((state_q == ST_RS_DAT) && prot));
  assign rd_next   = sh_done && (state_q == ST_PP_DAT);
  assign xfer      = state_q inside {ST_RS_CMD, ST_RS_DAT, ST_WE, ST_PP_CMD,
                                     ST_PP_ADR, ST_PP_DAT, ST_PL_CMD, ST_PL_DAT};
  assign start     = xfer && !pend_q;
  assign adr_sh    = addr_q >> (8 * (ADDR_BYTES - 1 - int'(ab_q)));

  always_comb
    unique case (state_q)
      ST_RS_CMD, ST_PL_CMD: tx_byte = OP_RDSR;
      ST_WE:                tx_byte = OP_WREN;
      ST_PP_CMD:            tx_byte = OP_PP;
      ST_PP_ADR:            tx_byte = adr_sh[7:0];
      ST_PP_DAT:            tx_byte = buf_dout;
      default:              tx_byte = 8'h00;
    endcase

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE; ret_q <= ST_IDLE; write_q <= 1'b0; wren_q <= 1'b0;
      addr_q <= '0; pend_q <= 1'b0; ab_q <= '0; left_q <= '0; cancel_q <= 1'b0;
    end else begin
      write_q <= write_i;
      wren_q  <= wren_i;
      if (state_q == ST_IDLE) addr_q <= addr_i;
      if (start) pend_q <= 1'b1;
      else if (sh_done) pend_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_RS_CMD; left_q <= buf_cnt;
        end
        ST_RS_CMD: if (sh_done) state_q <= ST_RS_DAT;
        ST_RS_DAT: if (sh_done) begin
          if (prot) begin state_q <= ST_CANCEL; cancel_q <= 1'b1; end
          else begin state_q <= ST_GAP; ret_q <= ST_WE; end
        end
        ST_GAP: state_q <= ret_q;
        ST_WE: if (sh_done) begin state_q <= ST_GAP; ret_q <= ST_PP_CMD; end
        ST_PP_CMD: if (sh_done) begin state_q <= ST_PP_ADR; ab_q <= '0; end
        ST_PP_ADR: if (sh_done) begin
          if (ab_q != AB_W'(ADDR_BYTES - 1)) ab_q <= ab_q + 1'b1;
          else if (left_q == '0) begin state_q <= ST_GAP; ret_q <= ST_PL_CMD; end
          else state_q <= ST_PP_DAT;
        end
        ST_PP_DAT: if (sh_done) begin
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) begin state_q <= ST_GAP; ret_q <= ST_PL_CMD; end
        end
        ST_PL_CMD: if (sh_done) state_q <= ST_PL_DAT;
        ST_PL_DAT: if (sh_done && !rx_byte[0]) state_q <= ST_IDLE;
        ST_CANCEL: begin
          cancel_q <= 1'b0;
          if (!cancel_q) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end

  assign busy_o          = (state_q != ST_IDLE) && (state_q != ST_CANCEL);
  assign illegal_write_o = (state_q == ST_CANCEL);
  assign spi_cs_no       = !xfer;

  pw_page_buf #(.DEPTH(PAGE_BYTES)) u_buf (
    .clk_i, .rst_ni,
    .push_i(load_i && (state_q == ST_IDLE)), .din_i(data_i),
    .clear_i(buf_clear), .rd_load_i(accept), .rd_next_i(rd_next),
    .dout_o(buf_dout), .count_o(buf_cnt)
  );

  pw_spi_shift u_shift (
    .clk_i, .rst_ni, .start_i(start), .tx_i(tx_byte), .miso_i(spi_miso_i),
    .busy_o(sh_busy), .done_o(sh_done), .rx_o(rx_byte),
    .sclk_o(spi_sclk_o), .mosi_o(spi_mosi_o)
  );

  a_r6_no_wren_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && write_q && !wren_q) |=> !busy_o);
  a_r7_cancel_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(illegal_write_o) |=> illegal_write_o ##1 !illegal_write_o);
  a_r7_cancel_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_write_o |-> (!busy_o && spi_cs_no));
  a_r3_sclk_low_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sclk_o);
  a_r3_one_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_busy |-> pend_q);
  a_r5_busy_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(state_q) == ST_PL_DAT || $past(state_q) == ST_RS_DAT));
endmodule

// File: tb/spi_page_writer_bench.sv
module spi_page_writer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic load = 1'b0, write = 1'b0, wren = 1'b0;
  logic [7:0] data = '0;
  logic [23:0] addr = '0;
  logic busy, ill, sclk, cs_n, mosi;
  logic miso = 1'b0;
  int checks = 0, errs = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spi_page_writer u_spi_page_writer (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .data_i(data), .addr_i(addr),
    .write_i(write), .wren_i(wren), .busy_o(busy), .illegal_write_o(ill),
    .spi_sclk_o(sclk), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural flash model
  logic [7:0] fmem [int];
  logic [2:0] bp = 3'd0;
  logic [7:0] sin = '0, fcmd = '0;
  logic [23:0] fadr = '0;
  logic fwel = 1'b0, fwip = 1'b0;
  int bc = 0, nb = 0, pp_cnt = 0, poll_left = 0;
  int n_wren = 0, n_pp = 0, last_len = 0, proto_err = 0;
  logic [23:0] last_adr = '0;
  int tx_log [$];
  time last_rise = 0, min_gap = 1000;

  always @(negedge cs_n) begin bc = 0; nb = 0; fcmd = '0; pp_cnt = 0; end

  always @(posedge sclk) if (!cs_n) begin
    logic [7:0] lo;
    if (bc != 0 && ($time - last_rise) < min_gap) min_gap = $time - last_rise;
    last_rise = $time;
    sin = {sin[6:0], mosi};
    bc++;
    if (bc == 8) begin
      bc = 0;
      if (nb == 0) fcmd = sin;
      else if (fcmd == 8'h02) begin
        if (nb <= 3) fadr = {fadr[15:0], sin};
        else begin
          lo = fadr[7:0] + 8'(pp_cnt);
          fmem[int'({fadr[23:8], lo})] = sin;
          pp_cnt++;
        end
      end else if (fcmd == 8'h05) begin
        if (poll_left > 0) poll_left--;
        if (poll_left == 0) fwip = 1'b0;
      end
      nb++;
    end
  end

  always @(negedge sclk) if (!cs_n && fcmd == 8'h05 && nb >= 1) begin
    logic [7:0] st;
    st = {3'b000, bp, fwel, fwip};
    miso <= st[7-bc];
  end

  always @(posedge cs_n) if (nb >= 1) begin
    tx_log.push_back(int'(fcmd));
    if (fcmd == 8'h06 && nb == 1) begin fwel = 1'b1; n_wren++; end
    if (fcmd == 8'h02 && nb >= 4) begin
      if (!fwel) proto_err++;
      n_pp++; last_len = pp_cnt; last_adr = fadr;
      fwel = 1'b0; fwip = 1'b1; poll_left = 3;
    end
  end

  // per-clock comparison against bench expectations
  int n_ill = 0, n_rise = 0;
  logic busy_d = 1'b0;
  always @(negedge clk) if (rst_n && !finished) begin
    chk(!(cs_n && sclk), "R3", "sclk high with cs high", int'(sclk), 0);
    chk(!(ill && busy), "R7", "busy during cancel", int'(busy), 0);
    if (ill) n_ill++;
    if (busy && !busy_d) n_rise++;
    busy_d = busy;
  end

  logic [7:0] q [$];
  task automatic load_bytes(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      load = 1'b1; data = 8'(base + i);
      q.push_back(8'(base + i));
      if (q.size() > 256) void'(q.pop_front());
      @(negedge clk);
    end
    load = 1'b0;
  endtask

  task automatic issue(input logic [23:0] a, input bit en);
    addr = a; wren = en; write = 1'b1;
    @(negedge clk); @(negedge clk);
    write = 1'b0; wren = 1'b0;
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic check_mem(input logic [23:0] a, input string req);
    int bad = 0, first_act = 0, first_exp = 0;
    for (int k = 0; k < q.size(); k++) begin
      logic [7:0] lo;
      int key;
      lo = a[7:0] + 8'(k);
      key = int'({a[23:8], lo});
      if (!fmem.exists(key) || fmem[key] != q[k]) begin
        if (bad == 0) begin
          first_act = fmem.exists(key) ? int'(fmem[key]) : -1;
          first_exp = int'(q[k]);
        end
        bad++;
      end
    end
    chk(bad == 0, req, "flash contents", first_act, first_exp);
    chk(last_len == q.size(), req, "data byte count", last_len, q.size());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int p, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R5", "reset busy", int'(busy), 0);
    chk(!ill, "R7", "reset illegal", int'(ill), 0);
    chk(cs_n, "R3", "reset cs", int'(cs_n), 1);
    chk(!sclk, "R3", "reset sclk", int'(sclk), 0);

    // R1/R3/R5: plain write with exact busy timing
    load_bytes(4, 8'h10);
    tx_log.delete();
    addr = 24'h001000; wren = 1'b1; write = 1'b1;
    @(negedge clk);
    chk(!busy, "R5", "busy one edge after command", int'(busy), 0);
    @(negedge clk);
    chk(busy, "R5", "busy two edges after command", int'(busy), 1);
    write = 1'b0; wren = 1'b0;
    load_bytes(3, 8'hE0);           // R1: ignored while busy
    repeat (3) void'(q.pop_back());
    while (busy) @(negedge clk);
    chk(fwip == 1'b0, "R5", "busy held until programming over", int'(fwip), 0);
    check_mem(24'h001000, "R1");
    chk(tx_log.size() == 4 && tx_log[0] == 5 && tx_log[1] == 6 && tx_log[2] == 2 && tx_log[3] == 5,
        "R3", "transaction order", tx_log.size(), 4);
    chk(last_adr == 24'h001000, "R3", "address bytes", int'(last_adr), 24'h001000);
    chk(min_gap == 16, "R3", "sclk period ns", int'(min_gap), 16);
    chk(proto_err == 0, "R3", "program without write-enable", proto_err, 0);
    q.delete();
    repeat (4) @(negedge clk);

    // R1/R9: loads during busy were dropped and buffer was emptied
    p = n_pp;
    issue(24'h004000, 1'b1);
    chk(n_pp == p + 1 && last_len == 0, "R9", "bytes after completed write", last_len, 0);

    // R6: low qualifier does nothing, buffer kept
    load_bytes(5, 8'h40);
    tx_log.delete(); p = n_rise;
    issue(24'h005000, 1'b0);
    chk(tx_log.size() == 0, "R6", "transactions with wren low", tx_log.size(), 0);
    chk(n_rise == p, "R6", "busy rises with wren low", n_rise - p, 0);
    issue(24'h005000, 1'b1);
    check_mem(24'h005000, "R9");
    q.delete();

    // R2: overflow keeps last 256 in load order
    load_bytes(300, 0);
    issue(24'h002000, 1'b1);
    check_mem(24'h002000, "R2");
    chk(fmem[24'h002000] == 8'd44, "R2", "oldest kept byte", int'(fmem[24'h002000]), 44);
    q.delete();

    // R4: mid-page start wraps within the page
    load_bytes(8, 8'hA0);
    issue(24'h0030FC, 1'b1);
    check_mem(24'h0030FC, "R4");
    chk(fmem.exists(24'h003000) && fmem[24'h003000] == 8'hA4, "R4", "wrapped byte",
        fmem.exists(24'h003000) ? int'(fmem[24'h003000]) : -1, 8'hA4);
    chk(!fmem.exists(24'h003100), "R4", "next page untouched", 1, 0);
    chk(last_adr == 24'h0030FC, "R4", "only start address sent", int'(last_adr), 24'h0030FC);
    q.delete();

    // R7: protection with BP=1 covers 0xFC0000 and above
    bp = 3'd1;
    load_bytes(6, 8'h60);
    tx_log.delete(); e = n_ill; p = n_wren;
    issue(24'hFC0000, 1'b1);
    chk(n_ill - e == 2, "R7", "illegal pulse length", n_ill - e, 2);
    chk(n_wren == p && tx_log.size() == 1, "R7", "no write-enable on cancel", n_wren - p, 0);
    chk(!busy, "R7", "busy after cancel", int'(busy), 0);
    q.delete();
    // R9: cancel emptied the buffer; boundary just below is writable
    p = n_pp; e = n_ill;
    issue(24'hFBFF00, 1'b1);
    chk(n_pp == p + 1 && n_ill == e, "R7", "below protected boundary", n_pp - p, 1);
    chk(last_len == 0, "R9", "bytes after cancelled write", last_len, 0);
    bp = 3'd7; e = n_ill;
    issue(24'h000000, 1'b1);
    chk(n_ill - e == 2, "R7", "BP=7 protects all", n_ill - e, 2);
    bp = 3'd0;

    // R8: holding command re-triggers a second write
    load_bytes(2, 8'hC0);
    p = n_pp; e = n_rise;
    addr = 24'h006000; wren = 1'b1; write = 1'b1;
    while (n_rise < e + 2) @(negedge clk);
    write = 1'b0; wren = 1'b0;
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(n_pp - p == 2, "R8", "page programs from held command", n_pp - p, 2);
    chk(last_len == 0, "R8", "second write data count", last_len, 0);
    chk(fmem[24'h006001] == 8'hC1, "R8", "first write data", int'(fmem[24'h006001]), 8'hC1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule